// File: doc/BRIEF.md
# Prioritized Exception Vector Generator

This block sits between the event sources of a processor core and its fetch logic. Every cycle it looks at three groups of event requests: critical exceptions, ordinary fixed-slot exceptions and external interrupt lines. Each source belongs to a fixed priority class. The block chooses the highest-class request, if any, and forms the handler address by ORing a software-programmed vector base with the winning source's offset.

The block keeps a small stack of the priority classes that are being serviced. This lets a higher-class event interrupt a running handler, while an event of equal or lower class waits. A return strobe from the core closes the current handler and restores the class that was interrupted. Interrupts and exceptions share one arbitration and address path. Interrupt offsets come from the interrupt controller on a 14-bit field per line. Fixed and critical offsets are computed inside the block.

Top module: `exv_vector_gen`

## Requirements
- R1: After a synchronous active-low reset, the following all read zero: `entry_pulse`, `tgt_addr`, `entry_cls`, `cur_cls` (class 0 is the idle level), the base register and `base_unaligned`.
- R2: With the defaults (4 interrupts, 8 fixed, 2 critical), the classes are: interrupt i has class 1+i; every fixed exception has class NUM_IRQ+1 (5); critical i has class NUM_IRQ+NUM_CRIT+1-i (critical 0 = 7, critical 1 = 6). Among requests in the same cycle the highest class wins. Among fixed exceptions the lowest index wins.
- R3: A request is taken only when its class is strictly greater than `cur_cls`. A request of equal or lower class causes no entry while that handler is active. When a request is taken, `cur_cls` becomes its class.
- R4: The target address is the base register ORed with the zero-extended offset. It is never their sum.
- R5: Fixed exception k has offset 4*k. Critical exception i has offset 0x200 + 0x80*i.
- R6: Interrupt i takes its offset from `irq_vec_off[14*i +: 14]` as sampled in the same cycle as the request.
- R7: A request sampled at a clock edge produces `entry_pulse`=1 in the following cycle. In that same cycle `tgt_addr` and `entry_cls` update. Both hold their value until the next entry.
- R8: When `evt_ret` is high and a handler is active, the class is popped into `cur_cls` and no request is taken in that cycle. Pending requests are considered again in the next cycle. When the block is idle, `evt_ret` has no effect, so a request in the same cycle is taken.
- R9: The class stack holds 4 saved classes. With 4 saved, no request is taken until a return.
- R10: A base write (`cfg_wr`) takes effect at the next edge. An entry in the same cycle uses the old base. `base_unaligned` is 1 whenever any of bits 13:0 of the base register is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_crit | input | NUM_CRIT | Critical exception requests |
| evt_fixed | input | NUM_FIXED | Fixed-slot exception requests |
| evt_irq | input | NUM_IRQ | External interrupt requests |
| irq_vec_off | input | NUM_IRQ*14 | Autovector offset per interrupt line |
| evt_ret | input | 1 | Return-from-event strobe |
| cfg_wr | input | 1 | Vector base write enable |
| cfg_base | input | ADDR_W | Vector base write data |
| entry_pulse | output | 1 | One-cycle handler entry indication |
| tgt_addr | output | ADDR_W | Handler target address |
| entry_cls | output | CLS_W | Class of the last entry |
| cur_cls | output | CLS_W | Class now being serviced (0 = idle) |
| base_unaligned | output | 1 | Base has nonzero bits below bit 14 |

## Verification
The hardest state to reach is a full class stack with a higher-class request waiting. This is the only state in which the depth limit, rather than the class compare, holds back an entry. The stimulus reaches it by raising the four interrupt lines one after another, so that each one preempts the last. It then holds a fixed exception, checks that no entry occurs through the return cycle, and checks that the entry appears in the cycle after the return. A long randomized phase then mixes requests, returns and base writes, and a behavioural model compares every output on every cycle.

// File: rtl/exv_pkg.sv
// Package: shared constants and offset functions for the vector generator.
// Assumes offsets are 14 bits wide and fit below 16384 bytes.
package exv_pkg;
    localparam int OFF_W = 14;

    // Offset of critical exception i: individually spaced slots above the fixed table.
    function automatic logic [OFF_W-1:0] crit_offset(input int i);
        return OFF_W'(32'h200 + 32'h80 * i);
    endfunction

    // Offset of fixed exception k: consecutive 4-byte slots from the base.
    function automatic logic [OFF_W-1:0] fixed_offset(input int k);
        return OFF_W'(4 * k);
    endfunction
endpackage

// File: rtl/exv_arbiter.sv
// Module: exv_arbiter
// Combinational winner selection over all event sources. Each source has a
// fixed class; the highest class wins, ties go to the lowest flat index.
// Assumes class 0 is never assigned to a source (it is the idle level).
module exv_arbiter
    import exv_pkg::*;
#(
    parameter int NUM_CRIT  = 2,
    parameter int NUM_FIXED = 8,
    parameter int NUM_IRQ   = 4,
    parameter int CLS_W     = 3
) (
    input  logic [NUM_CRIT-1:0]        evt_crit,
    input  logic [NUM_FIXED-1:0]       evt_fixed,
    input  logic [NUM_IRQ-1:0]         evt_irq,
    input  logic [NUM_IRQ*OFF_W-1:0]   irq_vec_off,
    output logic                       win_valid,
    output logic [CLS_W-1:0]           win_cls,
    output logic [OFF_W-1:0]           win_off
);
    localparam int NSRC     = NUM_CRIT + NUM_FIXED + NUM_IRQ;
    localparam int FIX_BASE = NUM_CRIT;
    localparam int IRQ_BASE = NUM_CRIT + NUM_FIXED;
    localparam int FIX_CLS  = NUM_IRQ + 1;

    logic             src_req [NSRC];
    logic [CLS_W-1:0] src_cls [NSRC];
    logic [OFF_W-1:0] src_off [NSRC];

    // Flatten the three source groups into one ordered table.
    genvar g;
    generate
        for (g = 0; g < NUM_CRIT; g++) begin : g_crit
            assign src_req[g] = evt_crit[g];
            assign src_cls[g] = CLS_W'(NUM_IRQ + NUM_CRIT + 1 - g);
            assign src_off[g] = crit_offset(g);
        end
        for (g = 0; g < NUM_FIXED; g++) begin : g_fix
            assign src_req[FIX_BASE+g] = evt_fixed[g];
            assign src_cls[FIX_BASE+g] = CLS_W'(FIX_CLS);
            assign src_off[FIX_BASE+g] = fixed_offset(g);
        end
        for (g = 0; g < NUM_IRQ; g++) begin : g_irq
            assign src_req[IRQ_BASE+g] = evt_irq[g];
            assign src_cls[IRQ_BASE+g] = CLS_W'(g + 1);
            assign src_off[IRQ_BASE+g] = irq_vec_off[g*OFF_W +: OFF_W];
        end
    endgenerate

    // Scan for the strictly highest class; the first source found keeps a tie.
    always_comb begin
        win_valid = 1'b0;
        win_cls   = '0;
        win_off   = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (src_req[s] && (src_cls[s] > win_cls)) begin
                win_valid = 1'b1;
                win_cls   = src_cls[s];
                win_off   = src_off[s];
            end
        end
    end
endmodule

// File: rtl/exv_class_stack.sv
// Module: exv_class_stack
// Holds the class being serviced and a LIFO of interrupted classes.
// Assumes push and pop are never requested together and that push only
// comes with a class above the current one.
module exv_class_stack #(
    parameter int DEPTH = 4,
    parameter int CLS_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [CLS_W-1:0] new_cls,
    output logic [CLS_W-1:0] cur_cls,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [CLS_W-1:0] stk [DEPTH];
    logic [PTR_W-1:0] ptr;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;

    assign full   = (ptr == PTR_W'(DEPTH));
    assign empty  = (ptr == '0);
    assign wr_idx = IDX_W'(ptr);
    assign rd_idx = IDX_W'(ptr - 1'b1);

    // Save the current class on entry, restore it on return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr     <= '0;
            cur_cls <= '0;
            for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
        end else if (push) begin
            stk[wr_idx] <= cur_cls;
            cur_cls     <= new_cls;
            ptr         <= ptr + 1'b1;
        end else if (pop) begin
            cur_cls <= stk[rd_idx];
            ptr     <= ptr - 1'b1;
        end
    end

    AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= PTR_W'(DEPTH)); // R9
    AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full); // R9
    AST_PUSH_HIGHER: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (new_cls > cur_cls)); // R3
    AST_POP_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> (cur_cls < $past(cur_cls))); // R8
endmodule

// File: rtl/exv_base_reg.sv
// Module: exv_base_reg
// Write-only vector base register with an alignment flag for the low
// offset-width bits. Assumes software writes the whole word at once.
module exv_base_reg #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] base,
    output logic              unaligned
);
    // Capture a new base on a configuration write.
    always_ff @(posedge clk) begin
        if (!rst_n)  base <= '0;
        else if (wr) base <= wdata;
    end

    assign unaligned = |base[OFF_W-1:0];

    AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(base)); // R10
endmodule

// File: rtl/exv_vector_gen.sv
// Module: exv_vector_gen (top)
// Picks the winning event, decides whether it preempts the class now being
// serviced, and registers the handler address (base OR offset) together with
// a one-cycle entry pulse. Assumes event requests are levels that the
// sources hold until they are serviced.
module exv_vector_gen
    import exv_pkg::*;
#(
    parameter int NUM_CRIT  = 2,
    parameter int NUM_FIXED = 8,
    parameter int NUM_IRQ   = 4,
    parameter int ADDR_W    = 32,
    parameter int DEPTH     = 4,
    localparam int CLS_W    = $clog2(NUM_IRQ + NUM_CRIT + 2)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CRIT-1:0]      evt_crit,
    input  logic [NUM_FIXED-1:0]     evt_fixed,
    input  logic [NUM_IRQ-1:0]       evt_irq,
    input  logic [NUM_IRQ*OFF_W-1:0] irq_vec_off,
    input  logic                     evt_ret,
    input  logic                     cfg_wr,
    input  logic [ADDR_W-1:0]        cfg_base,
    output logic                     entry_pulse,
    output logic [ADDR_W-1:0]        tgt_addr,
    output logic [CLS_W-1:0]         entry_cls,
    output logic [CLS_W-1:0]         cur_cls,
    output logic                     base_unaligned
);
    logic             win_valid;
    logic [CLS_W-1:0] win_cls;
    logic [OFF_W-1:0] win_off;
    logic             stk_full;
    logic             stk_empty;
    logic             do_pop;
    logic             do_take;
    logic [ADDR_W-1:0] base;

    exv_arbiter #(
        .NUM_CRIT (NUM_CRIT),
        .NUM_FIXED(NUM_FIXED),
        .NUM_IRQ  (NUM_IRQ),
        .CLS_W    (CLS_W)
    ) u_arb (
        .evt_crit   (evt_crit),
        .evt_fixed  (evt_fixed),
        .evt_irq    (evt_irq),
        .irq_vec_off(irq_vec_off),
        .win_valid  (win_valid),
        .win_cls    (win_cls),
        .win_off    (win_off)
    );

    exv_base_reg #(
        .ADDR_W(ADDR_W),
        .OFF_W (OFF_W)
    ) u_base (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (cfg_wr),
        .wdata    (cfg_base),
        .base     (base),
        .unaligned(base_unaligned)
    );

    // A return with an active handler owns the cycle; otherwise a strictly
    // higher class may enter while the stack has room.
    assign do_pop  = evt_ret && !stk_empty;
    assign do_take = !do_pop && win_valid && (win_cls > cur_cls) && !stk_full;

    exv_class_stack #(
        .DEPTH(DEPTH),
        .CLS_W(CLS_W)
    ) u_stk (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (do_take),
        .pop    (do_pop),
        .new_cls(win_cls),
        .cur_cls(cur_cls),
        .full   (stk_full),
        .empty  (stk_empty)
    );

    // Register the entry pulse, handler address and entered class.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_pulse <= 1'b0;
            tgt_addr    <= '0;
            entry_cls   <= '0;
        end else begin
            entry_pulse <= do_take;
            if (do_take) begin
                tgt_addr  <= base | ADDR_W'(win_off);
                entry_cls <= win_cls;
            end
        end
    end

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !entry_pulse |-> $stable(tgt_addr)); // R7
    AST_ADDR_HAS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        entry_pulse |-> ((tgt_addr & $past(base)) == $past(base))); // R4
    AST_NO_ENTRY_AFTER_RET: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_ret && !stk_empty) |=> !entry_pulse); // R8
    AST_ENTRY_RAISES_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        entry_pulse |-> (cur_cls == entry_cls)); // R3
endmodule

// File: tb/exv_vector_gen_tb.sv
// Bench: drives inputs at the falling edge, runs a behavioural model at the
// rising edge and compares every output on every falling edge.
module exv_vector_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 2, NF = 8, NI = 4, AW = 32, OW = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NC-1:0] evt_crit = '0;
    logic [NF-1:0] evt_fixed = '0;
    logic [NI-1:0] evt_irq = '0;
    logic [NI*OW-1:0] irq_vec_off = '0;
    logic evt_ret = 1'b0, cfg_wr = 1'b0;
    logic [AW-1:0] cfg_base = '0;
    logic entry_pulse, base_unaligned;
    logic [AW-1:0] tgt_addr;
    logic [2:0] entry_cls, cur_cls;

    int checks = 0, errors = 0;

    // Model state.
    int m_cur = 0, m_ecls = 0;
    bit m_entry = 0;
    logic [AW-1:0] m_base = '0, m_tgt = '0;
    int m_stk[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    exv_vector_gen u_dut (
        .clk(clk), .rst_n(rst_n), .evt_crit(evt_crit), .evt_fixed(evt_fixed),
        .evt_irq(evt_irq), .irq_vec_off(irq_vec_off), .evt_ret(evt_ret),
        .cfg_wr(cfg_wr), .cfg_base(cfg_base), .entry_pulse(entry_pulse),
        .tgt_addr(tgt_addr), .entry_cls(entry_cls), .cur_cls(cur_cls),
        .base_unaligned(base_unaligned)
    );

    // Behavioural reference model, evaluated at each rising edge.
    always @(posedge clk) begin
        int bc; int bo;
        if (!rst_n) begin
            m_cur = 0; m_ecls = 0; m_entry = 0; m_base = '0; m_tgt = '0;
            m_stk.delete();
        end else begin
            bc = 0; bo = 0;
            for (int i = 0; i < NC; i++)
                if (evt_crit[i] && (NI + NC + 1 - i) > bc) begin bc = NI + NC + 1 - i; bo = 'h200 + 'h80 * i; end
            for (int k = 0; k < NF; k++)
                if (evt_fixed[k] && (NI + 1) > bc) begin bc = NI + 1; bo = 4 * k; end
            for (int i = 0; i < NI; i++)
                if (evt_irq[i] && (i + 1) > bc) begin bc = i + 1; bo = int'(irq_vec_off[i*OW +: OW]); end
            m_entry = 0;
            if (evt_ret && m_stk.size() > 0) begin
                m_cur = m_stk.pop_back();
            end else if (bc > m_cur && m_stk.size() < 4) begin
                m_stk.push_back(m_cur);
                m_cur = bc; m_entry = 1; m_ecls = bc;
                m_tgt = m_base | AW'(bo);
            end
            if (cfg_wr) m_base = cfg_base;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: inputs already set; compare all outputs with the model after it.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        chk("R7 entry_pulse", 32'(entry_pulse), 32'(m_entry));
        chk("R4 tgt_addr", tgt_addr, m_tgt);
        chk("R2 entry_cls", 32'(entry_cls), 32'(m_ecls));
        chk("R3 cur_cls", 32'(cur_cls), 32'(m_cur));
        chk("R10 base_unaligned", 32'(base_unaligned), 32'(|m_base[13:0]));
    endtask

    task automatic clear();
        evt_crit = '0; evt_fixed = '0; evt_irq = '0; evt_ret = 0; cfg_wr = 0;
    endtask

    task automatic wr_base(input logic [31:0] b);
        cfg_wr = 1; cfg_base = b; tick(); cfg_wr = 0;
    endtask

    task automatic do_ret();
        evt_ret = 1; tick(); evt_ret = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk); tick(); tick();
        rst_n = 1; clear(); tick();
        // R1 reset state
        chk("R1 entry", 32'(entry_pulse), 0); chk("R1 tgt", tgt_addr, 0);
        chk("R1 cur", 32'(cur_cls), 0); chk("R1 unaligned", 32'(base_unaligned), 0);

        wr_base(32'h8000_0000);
        chk("R10 aligned base", 32'(base_unaligned), 0);

        // R5 fixed slot 3 -> offset 0xC
        evt_fixed[3] = 1; tick(); clear();
        chk("R5 fixed entry", 32'(entry_pulse), 1);
        chk("R5 fixed tgt", tgt_addr, 32'h8000_000C);
        chk("R2 fixed cls", 32'(entry_cls), 5);
        tick();
        chk("R7 pulse one cycle", 32'(entry_pulse), 0);
        chk("R7 tgt held", tgt_addr, 32'h8000_000C);
        do_ret();
        chk("R8 back to idle", 32'(cur_cls), 0);

        // R2 simultaneous: crit1 beats fixed2 and irq1
        evt_irq[1] = 1; evt_fixed[2] = 1; evt_crit[1] = 1; tick(); clear();
        chk("R2 winner cls", 32'(entry_cls), 6);
        chk("R5 crit1 tgt", tgt_addr, 32'h8000_0280);
        // R3 equal and lower classes wait
        evt_crit[1] = 1; evt_fixed[0] = 1; tick(); clear();
        chk("R3 equal/lower no entry", 32'(entry_pulse), 0);
        evt_crit[0] = 1; tick(); clear();
        chk("R3 higher preempts", 32'(entry_pulse), 1);
        chk("R3 crit0 cls", 32'(entry_cls), 7);
        chk("R5 crit0 tgt", tgt_addr, 32'h8000_0200);
        do_ret(); chk("R8 restore 6", 32'(cur_cls), 6);
        do_ret(); chk("R8 restore idle", 32'(cur_cls), 0);

        // R6/R8: return while idle is ignored, interrupt taken
        irq_vec_off[2*OW +: OW] = 14'h1234;
        evt_ret = 1; evt_irq[2] = 1; tick(); clear();
        chk("R8 idle ret ignored", 32'(entry_pulse), 1);
        chk("R6 irq tgt", tgt_addr, 32'h8000_1234);
        chk("R2 irq2 cls", 32'(entry_cls), 3);
        do_ret();

        // R4/R10: OR not add with an unaligned base
        wr_base(32'h8000_0004);
        chk("R10 unaligned flag", 32'(base_unaligned), 1);
        evt_fixed[1] = 1; tick(); clear();
        chk("R4 or not add", tgt_addr, 32'h8000_0004);
        do_ret();
        // R10: same-cycle write uses the old base
        cfg_wr = 1; cfg_base = 32'h4000_0000; evt_fixed[2] = 1; tick(); clear();
        chk("R10 old base used", tgt_addr, 32'h8000_000C);
        chk("R10 new base aligned", 32'(base_unaligned), 0);
        do_ret();

        // R9 nesting fill then blocked
        for (int i = 0; i < NI; i++) irq_vec_off[i*OW +: OW] = OW'(32'h100 * (i + 1));
        for (int i = 0; i < NI; i++) begin
            evt_irq[i] = 1; tick(); clear();
            chk("R9 nest entry", 32'(entry_pulse), 1);
        end
        evt_fixed[0] = 1; tick();
        chk("R9 full blocks", 32'(entry_pulse), 0);
        evt_ret = 1; tick(); evt_ret = 0;
        chk("R8 no entry in ret cycle", 32'(entry_pulse), 0);
        tick(); clear();
        chk("R8 reevaluated entry", 32'(entry_pulse), 1);
        chk("R9 fixed tgt", tgt_addr, 32'h4000_0000);
        for (int i = 0; i < 4; i++) do_ret();
        chk("R8 unwound idle", 32'(cur_cls), 0);

        // Randomized mix compared against the model every cycle
        for (int n = 0; n < 3000; n++) begin
            clear();
            evt_crit  = (($urandom % 8) == 0) ? NC'($urandom) : '0;
            evt_fixed = (($urandom % 4) == 0) ? NF'($urandom) : '0;
            evt_irq   = (($urandom % 3) == 0) ? NI'($urandom) : '0;
            irq_vec_off = {$urandom, $urandom};
            evt_ret = (($urandom % 3) == 0);
            if (($urandom % 50) == 0) begin
                cfg_wr = 1;
                cfg_base = (($urandom % 4) == 0) ? $urandom : ($urandom & 32'hFFFF_C000);
            end
            tick();
        end
        clear(); tick();

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule